// File: doc/BRIEF.md
# Toy 16-bit Instruction Decoder

This block is the purely combinational control decoder of a single-cycle processor whose instructions are one 16-bit word each. It splits the instruction word into register numbers, a sign-extended short immediate and a long jump offset. From the 4-bit opcode it also produces every steering signal the datapath needs. These are the register-file write strobe, the choice of destination field, the ALU function, the ALU second-operand source, the data-memory write strobe, the load-result select, and the branch and jump flags.

The surrounding datapath owns the ALU, the program counter and both memories. It feeds the fetched word in on `instr_i` and uses the outputs in the same cycle. For a conditional branch, the datapath takes the branch when `branch_o` is high and its ALU reports a zero result from the subtraction this decoder selects. Opcodes outside the defined set decode to a no-op that changes no architectural state.

Top module: `toy_decoder`

## Requirements
- R1: `rs_addr_o` always equals instruction bits 11:8 and `rt_addr_o` always equals bits 7:4, whatever the opcode.
- R2: `imm_o` is instruction bits 3:0 sign-extended to 16 bits, so bit 3 is copied into bits 15:4.
- R3: `jmp_off_o` always equals instruction bits 11:0.
- R4: Opcodes 0010 (add), 0011 (subtract), 0100 (and) and 0101 (or) set `reg_we_o`=1 and `dst_rd_o`=1, and make `wr_addr_o` equal bits 3:0. They also set `alu_imm_o`=0, `mem_to_reg_o`=0, `mem_we_o`=0, `branch_o`=0 and `jump_o`=0. `alu_op_o` is 00 for add, 01 for subtract, 10 for and and 11 for or.
- R5: Opcode 0000 (load) sets `reg_we_o`=1, `dst_rd_o`=0 with `wr_addr_o` equal to bits 7:4, `alu_op_o`=00, `alu_imm_o`=1, `mem_to_reg_o`=1, `mem_we_o`=0, `branch_o`=0 and `jump_o`=0.
- R6: Opcode 0001 (store) sets `mem_we_o`=1, `reg_we_o`=0, `alu_op_o`=00, `alu_imm_o`=1, `mem_to_reg_o`=0, `branch_o`=0 and `jump_o`=0.
- R7: Opcode 0111 (branch if equal) sets `branch_o`=1, `alu_op_o`=01, `alu_imm_o`=0, and drives `reg_we_o`, `mem_we_o`, `mem_to_reg_o` and `jump_o` to 0.
- R8: Opcode 1000 (jump) sets `jump_o`=1 and drives `reg_we_o`, `mem_we_o`, `branch_o` and `mem_to_reg_o` to 0.
- R9: Opcodes 0110 and 1001 through 1111 drive `reg_we_o`, `mem_we_o`, `branch_o`, `jump_o`, `mem_to_reg_o`, `alu_imm_o` and `dst_rd_o` to 0 and `alu_op_o` to 00.
- R10: At most one of `reg_we_o`, `mem_we_o`, `branch_o` and `jump_o` is high for any instruction. `mem_to_reg_o` is high only together with `reg_we_o`.
- R11: `wr_addr_o` equals bits 3:0 when `dst_rd_o` is 1 and bits 7:4 when it is 0, for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Fetched instruction word |
| rs_addr_o | output | 4 | First source register number |
| rt_addr_o | output | 4 | Second source register number |
| wr_addr_o | output | 4 | Selected destination register number |
| imm_o | output | 16 | Sign-extended 4-bit offset |
| jmp_off_o | output | 12 | Raw 12-bit jump offset |
| reg_we_o | output | 1 | Register-file write enable |
| dst_rd_o | output | 1 | Destination select: 1 = bits 3:0, 0 = bits 7:4 |
| alu_op_o | output | 2 | ALU function: 00 add, 01 sub, 10 and, 11 or |
| alu_imm_o | output | 1 | ALU second operand: 1 = immediate, 0 = register |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_to_reg_o | output | 1 | Write-back source: 1 = memory data, 0 = ALU |
| branch_o | output | 1 | Conditional branch on ALU zero |
| jump_o | output | 1 | Unconditional jump |

## Verification
The decoder holds no state, so every output is due in the same cycle that the instruction word is applied. The bench drives a new word just after a rising edge and pushes that word into a queue. A monitor pops the word at the following falling edge, half a clock period later, when the combinational paths have long settled. It compares each output against a model written from the requirements. Each instruction is therefore checked exactly once, in its own cycle, and no result leaks into the next word's comparison.

// File: rtl/toy_dec_pkg.sv
package toy_dec_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int RA_W    = 4;
  localparam int OFF_W   = 4;
  localparam int JOFF_W  = 12;

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - RA_W;
  localparam int RT_LSB  = RS_LSB - RA_W;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_OR    = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'b1000;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_OR  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    alu_op_e alu_op;
    logic    alu_imm;
    logic    mem_we;
    logic    mem_to_reg;
    logic    branch;
    logic    jump;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{
    reg_we: 1'b0, dst_rd: 1'b0, alu_op: ALU_ADD, alu_imm: 1'b0,
    mem_we: 1'b0, mem_to_reg: 1'b0, branch: 1'b0, jump: 1'b0
  };

  // Map an arithmetic opcode to its ALU function.
  function automatic alu_op_e arith_fn(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_SUB: arith_fn = ALU_SUB;
      OPC_AND: arith_fn = ALU_AND;
      OPC_OR:  arith_fn = ALU_OR;
      default: arith_fn = ALU_ADD;
    endcase
  endfunction

  // True for the four register-register opcodes.
  function automatic logic is_arith(input logic [OPC_W-1:0] opc);
    is_arith = (opc == OPC_ADD) || (opc == OPC_SUB) ||
               (opc == OPC_AND) || (opc == OPC_OR);
  endfunction

endpackage

// File: rtl/toy_dec_fields.sv
module toy_dec_fields
  import toy_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OPC_W-1:0]   opc_o,
  output logic [RA_W-1:0]    rs_o,
  output logic [RA_W-1:0]    rt_o,
  output logic [RA_W-1:0]    rd_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [JOFF_W-1:0]  joff_o
);

  assign opc_o  = instr_i[OPC_LSB +: OPC_W];
  assign rs_o   = instr_i[RS_LSB  +: RA_W];
  assign rt_o   = instr_i[RT_LSB  +: RA_W];
  assign rd_o   = instr_i[0 +: RA_W];
  assign off_o  = instr_i[0 +: OFF_W];
  assign joff_o = instr_i[0 +: JOFF_W];

endmodule

// File: rtl/toy_dec_ctrl.sv
module toy_dec_ctrl
  import toy_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o,
  output logic             undef_o
);

  always_comb begin
    ctrl_o  = CTRL_NOP;
    undef_o = 1'b0;
    if (is_arith(opc_i)) begin
      ctrl_o.reg_we = 1'b1;
      ctrl_o.dst_rd = 1'b1;
      ctrl_o.alu_op = arith_fn(opc_i);
    end else begin
      case (opc_i)
        OPC_LOAD: begin
          ctrl_o.reg_we     = 1'b1;
          ctrl_o.alu_imm    = 1'b1;
          ctrl_o.mem_to_reg = 1'b1;
        end
        OPC_STORE: begin
          ctrl_o.mem_we  = 1'b1;
          ctrl_o.alu_imm = 1'b1;
        end
        OPC_BREQ: begin
          ctrl_o.branch = 1'b1;
          ctrl_o.alu_op = ALU_SUB;
        end
        OPC_JUMP: ctrl_o.jump = 1'b1;
        default:  undef_o = 1'b1;
      endcase
    end
  end

  // Undefined opcodes must leave all state-changing strobes low (R9).
  always_comb begin
    if (!$isunknown(opc_i)) begin
      p_undef_quiet_r9: assert (!undef_o ||
        (!ctrl_o.reg_we && !ctrl_o.mem_we && !ctrl_o.branch && !ctrl_o.jump))
        else $error("undefined opcode drives a strobe");
    end
  end

endmodule

// File: rtl/toy_dec_imm.sv
module toy_dec_imm #(
  parameter int OFF_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] imm_o
);

  localparam int EXT_W = DATA_W - OFF_W;

  assign imm_o[OFF_W-1:0] = off_i;

  generate
    for (genvar g = 0; g < EXT_W; g++) begin : g_ext
      assign imm_o[OFF_W + g] = off_i[OFF_W-1];
    end
  endgenerate

  // Upper bits are all copies of the offset sign (R2).
  always_comb begin
    if (!$isunknown(off_i)) begin
      p_sign_fill_r2: assert ((imm_o[DATA_W-1:OFF_W] == '0) ||
                              (imm_o[DATA_W-1:OFF_W] == '1))
        else $error("immediate extension not uniform");
    end
  end

endmodule

// File: rtl/toy_decoder.sv
module toy_decoder
  import toy_dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [RA_W-1:0]    rs_addr_o,
  output logic [RA_W-1:0]    rt_addr_o,
  output logic [RA_W-1:0]    wr_addr_o,
  output logic [DATA_W-1:0]  imm_o,
  output logic [JOFF_W-1:0]  jmp_off_o,
  output logic               reg_we_o,
  output logic               dst_rd_o,
  output logic [1:0]         alu_op_o,
  output logic               alu_imm_o,
  output logic               mem_we_o,
  output logic               mem_to_reg_o,
  output logic               branch_o,
  output logic               jump_o
);

  logic [OPC_W-1:0]  f_opc;
  logic [RA_W-1:0]   f_rs;
  logic [RA_W-1:0]   f_rt;
  logic [RA_W-1:0]   f_rd;
  logic [OFF_W-1:0]  f_off;
  logic [JOFF_W-1:0] f_joff;
  ctrl_t             ctrl;
  logic              undef_opc;

  toy_dec_fields u_fields (
    .instr_i (instr_i),
    .opc_o   (f_opc),
    .rs_o    (f_rs),
    .rt_o    (f_rt),
    .rd_o    (f_rd),
    .off_o   (f_off),
    .joff_o  (f_joff)
  );

  toy_dec_ctrl u_ctrl (
    .opc_i   (f_opc),
    .ctrl_o  (ctrl),
    .undef_o (undef_opc)
  );

  toy_dec_imm #(
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_imm (
    .off_i (f_off),
    .imm_o (imm_o)
  );

  assign rs_addr_o    = f_rs;
  assign rt_addr_o    = f_rt;
  assign wr_addr_o    = ctrl.dst_rd ? f_rd : f_rt;
  assign jmp_off_o    = f_joff;
  assign reg_we_o     = ctrl.reg_we;
  assign dst_rd_o     = ctrl.dst_rd;
  assign alu_op_o     = ctrl.alu_op;
  assign alu_imm_o    = ctrl.alu_imm;
  assign mem_we_o     = ctrl.mem_we;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign branch_o     = ctrl.branch;
  assign jump_o       = ctrl.jump;

  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_one_action_r10: assert ($onehot0({reg_we_o, mem_we_o, branch_o, jump_o}))
        else $error("more than one action strobe");
      p_load_path_r5: assert (!mem_to_reg_o || (reg_we_o && alu_imm_o && !dst_rd_o))
        else $error("load write-back without load controls");
      p_store_addr_r6: assert (!mem_we_o || (alu_imm_o && !mem_to_reg_o &&
                                             alu_op_o == ALU_ADD))
        else $error("store without immediate address add");
      p_branch_sub_r7: assert (!branch_o || (alu_op_o == ALU_SUB && !alu_imm_o))
        else $error("branch without register subtract");
      p_rd_dest_r4: assert (!dst_rd_o || (reg_we_o && !alu_imm_o))
        else $error("Rd destination outside register-register ops");
    end
  end

endmodule

// File: tb/test_toy_decoder.sv
module test_toy_decoder;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr;
  logic [3:0]  rs_a, rt_a, wr_a;
  logic [15:0] imm;
  logic [11:0] joff;
  logic        reg_we, dst_rd, alu_imm, mem_we, m2r, br, jmp;
  logic [1:0]  alu_op;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  logic [15:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  toy_decoder i_toy_decoder (
    .instr_i      (instr),
    .rs_addr_o    (rs_a),
    .rt_addr_o    (rt_a),
    .wr_addr_o    (wr_a),
    .imm_o        (imm),
    .jmp_off_o    (joff),
    .reg_we_o     (reg_we),
    .dst_rd_o     (dst_rd),
    .alu_op_o     (alu_op),
    .alu_imm_o    (alu_imm),
    .mem_we_o     (mem_we),
    .mem_to_reg_o (m2r),
    .branch_o     (br),
    .jump_o       (jmp)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp,
                     input logic [15:0] ins);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, ins, act, exp);
    end
  endtask

  // Independent reference model, written from the requirement list.
  task automatic compare(input logic [15:0] w);
    logic [3:0] op;
    string      rq;
    logic e_we, e_rd, e_imm, e_mw, e_m2r, e_br, e_j;
    logic [1:0] e_op;
    op = w[15:12];
    e_we = 0; e_rd = 0; e_imm = 0; e_mw = 0; e_m2r = 0; e_br = 0; e_j = 0; e_op = 2'b00;
    case (op)
      4'h2: begin rq = "R4"; e_we = 1; e_rd = 1; e_op = 2'b00; end
      4'h3: begin rq = "R4"; e_we = 1; e_rd = 1; e_op = 2'b01; end
      4'h4: begin rq = "R4"; e_we = 1; e_rd = 1; e_op = 2'b10; end
      4'h5: begin rq = "R4"; e_we = 1; e_rd = 1; e_op = 2'b11; end
      4'h0: begin rq = "R5"; e_we = 1; e_imm = 1; e_m2r = 1; end
      4'h1: begin rq = "R6"; e_mw = 1; e_imm = 1; end
      4'h7: begin rq = "R7"; e_br = 1; e_op = 2'b01; end
      4'h8: begin rq = "R8"; e_j = 1; end
      default: rq = "R9";
    endcase
    chk("R1", "rs", {12'h0, rs_a}, {12'h0, w[11:8]}, w);
    chk("R1", "rt", {12'h0, rt_a}, {12'h0, w[7:4]}, w);
    chk("R2", "imm", imm, {{12{w[3]}}, w[3:0]}, w);
    chk("R3", "joff", {4'h0, joff}, {4'h0, w[11:0]}, w);
    chk(rq, "reg_we", {15'h0, reg_we}, {15'h0, e_we}, w);
    chk(rq, "dst_rd", {15'h0, dst_rd}, {15'h0, e_rd}, w);
    chk(rq, "alu_op", {14'h0, alu_op}, {14'h0, e_op}, w);
    chk(rq, "alu_imm", {15'h0, alu_imm}, {15'h0, e_imm}, w);
    chk(rq, "mem_we", {15'h0, mem_we}, {15'h0, e_mw}, w);
    chk(rq, "mem_to_reg", {15'h0, m2r}, {15'h0, e_m2r}, w);
    chk(rq, "branch", {15'h0, br}, {15'h0, e_br}, w);
    chk(rq, "jump", {15'h0, jmp}, {15'h0, e_j}, w);
    chk("R11", "wr_addr", {12'h0, wr_a}, {12'h0, e_rd ? w[3:0] : w[7:4]}, w);
    chk("R10", "one_action", {15'h0, 1'(($countones({reg_we, mem_we, br, jmp}) <= 1)
                               && (!m2r || reg_we))}, 16'h1, w);
  endtask

  // Driver: applies a word just after a rising edge and records it.
  task automatic drive(input logic [15:0] w);
    @(posedge clk);
    instr = w;
    sb_q.push_back(w);
  endtask

  // Monitor: outputs are combinational, due half a period later.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [11:0] pats [6];
    pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'h5A7;
    pats[3] = 12'h3C8; pats[4] = 12'hE61; pats[5] = 12'h9BF;
    // Reset state: an undefined opcode is held while reset is low (R9).
    instr = 16'hF000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(16'hF000);
    rst_n = 1'b1;
    // Every opcode with several field patterns (R1-style coverage per opcode).
    for (int o = 0; o < 16; o++) begin
      for (int p = 0; p < 6; p++) drive({o[3:0], pats[p]});
    end
    // Offset sign boundaries for R2 across memory and branch opcodes.
    drive(16'h0127); drive(16'h0128); drive(16'h112F); drive(16'h7340);
    drive(16'h7348); drive(16'h8800); drive(16'h87FF);
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule